// File: doc/BRIEF.md
# Parallel Character-Display Bus Cycle Engine

This block carries out one register access at a time to a character display controller attached through a parallel bus of the 6800 kind. The bus has a register-select line, a read/write line, an enable strobe and an eight-bit data path. Because the data path is bidirectional, it is split here into an output value, an output enable and an input value. A requester hands over one access: the register select, the direction, a byte to write, and a flag that chooses a full-byte transfer or a two-nibble transfer on the upper four data lines. The engine then produces the strobe sequence. Every setup, pulse-width, cycle and hold interval is a nanosecond minimum rounded up to whole cycles of the system clock.

When the access ends, the engine pulses `done` for one cycle. Read results appear on `rd_data`. A poll flag turns the access into a loop of status reads that stops when the controller's busy bit clears. The loop also stops after a programmable number of reads, and in that case the engine flags a timeout. Command sequencing, the electrical levels and any display content are left to the requester.

Top module: `lcdbus_engine`

## Requirements
- R1: While reset is held and right after it, `lcd_e`, `lcd_db_oe`, `done`, `busy_o` and `timeout_err` are all 0.
- R2: `lcd_rs` and `lcd_rw` hold their access values for at least ceil(30 ns / clock period) cycles (2 at 20 ns) before `lcd_e` rises. They do not change while `lcd_e` is high.
- R3: Each `lcd_e` high pulse lasts exactly max(ceil(150 ns), ceil(40 ns), ceil(100 ns)+1) cycles, which is 8 at 20 ns. Between two pulses `lcd_e` stays low for at least max(ceil(150 ns), ceil(400 ns) minus the high count) cycles, which is 12 at 20 ns.
- R4: On a write, `lcd_db_oe` is 1 and `lcd_db_out` carries the write value up to and including the last high cycle of every strobe. In byte mode (`req_nibble`=0) that value is the full byte.
- R5: On a read, `lcd_db_oe` stays 0 for the whole access. In byte mode `rd_data` takes the `lcd_db_in` value seen in the last high cycle of the strobe.
- R6: In nibble mode (`req_nibble`=1) an access uses two strobes. The first carries data bits 7..4 on `lcd_db_out[7:4]` and the second carries bits 3..0 there, with `lcd_db_out[3:0]`=0 on both. A read assembles bits 7..4 from `lcd_db_in[7:4]` of the first strobe and bits 3..0 from `lcd_db_in[7:4]` of the second, and ignores `lcd_db_in[3:0]`.
- R7: `done` is a one-cycle pulse with `lcd_e` low. It comes after exactly one strobe per byte in byte mode and two per byte in nibble mode.
- R8: A request made while `busy_o`=1 is ignored. It causes no extra strobe and does not alter the access in progress.
- R9: With `req_poll`=1 the engine issues status reads (`lcd_rs`=0, `lcd_rw`=1) whatever `req_rs` and `req_rw` say. It repeats whole-byte reads while bit 7 of the assembled byte is 1, and it places the final byte on `rd_data`.
- R10: If `poll_limit` reads all show bit 7 set, the poll ends with `timeout_err`=1 in the same cycle as `done`, and `rd_data` holds the last status byte. A `poll_limit` of 0 behaves as 1.
- R11: A write access leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| req_rw | input | 1 | Direction: 1 read, 0 write |
| req_data | input | 8 | Byte to write |
| req_nibble | input | 1 | 1 selects two-nibble transfer on the upper lines |
| req_poll | input | 1 | 1 turns the request into a busy-poll loop |
| poll_limit | input | POLL_W | Maximum status reads in a poll |
| busy_o | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Poll ended with busy still set (with done) |
| rd_data | output | 8 | Last read byte |
| lcd_rs | output | 1 | Bus register select |
| lcd_rw | output | 1 | Bus read/write |
| lcd_e | output | 1 | Bus enable strobe |
| lcd_db_out | output | 8 | Data driven toward the display |
| lcd_db_oe | output | 1 | Output enable for lcd_db_out |
| lcd_db_in | input | 8 | Data returned by the display |

## Verification
The main function is tried with byte and nibble writes to both registers, byte and nibble reads, and a plain status read. Comparing these separates the nibble ordering and the zeroed low lines from the byte path. Reads are fed distinct garbage on the low lines in nibble mode, which shows whether those lines leak into the result. Poll runs with the busy bit clearing after a few reads, in byte and nibble form, separate whole-byte polling from per-nibble polling. Poll runs that never clear, including a zero limit, separate the timeout count from the success path. A request made mid-access shows whether the engine ignores requests while busy.

// File: rtl/lcdbus_pkg.sv
// Shared types and compile-time helpers for the display bus cycle engine.
// Assumes all timing values are positive nanosecond figures.
package lcdbus_pkg;

    // Round a nanosecond minimum up to whole clock cycles.
    function automatic int ns2cyc(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Phases of one enable strobe.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_EHI   = 2'd2,
        PH_ELO   = 2'd3
    } phase_t;

    // Access sequencer states.
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_LAUNCH = 2'd1,
        SQ_WAIT   = 2'd2
    } seq_t;

endpackage

// File: rtl/lcdbus_strobe.sv
// One enable strobe: address setup, enable high, then enable low (hold and
// recovery). It starts on a one-cycle start pulse while idle. It flags the
// last high cycle (read sampling point) and the last low cycle (finish).
// Assumes every count parameter is at least 1.
module lcdbus_strobe
    import lcdbus_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int HIGH_CYC  = 8,
    parameter int LOW_CYC   = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic e_out,
    output logic sample,
    output logic fin
);
    localparam int MAXC  = imax(SETUP_CYC, imax(HIGH_CYC, LOW_CYC));
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam int RUN_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] S_LD = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] H_LD = CNT_W'(HIGH_CYC - 1);
    localparam logic [CNT_W-1:0] L_LD = CNT_W'(LOW_CYC - 1);

    phase_t           ph;
    logic [CNT_W-1:0] cnt;

    // Advance the strobe phase when its cycle count runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        ph  <= PH_SETUP;
                        cnt <= S_LD;
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        ph  <= PH_EHI;
                        cnt <= H_LD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_EHI: begin
                    if (cnt == '0) begin
                        ph  <= PH_ELO;
                        cnt <= L_LD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (cnt == '0) ph <= PH_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
            endcase
        end
    end

    assign e_out  = (ph == PH_EHI);
    assign sample = (ph == PH_EHI) && (cnt == '0);
    assign fin    = (ph == PH_ELO) && (cnt == '0);

    // Run lengths of the enable level, kept for the timing checks.
    logic [RUN_W-1:0] run_hi;
    logic [RUN_W-1:0] run_lo;

    // Count consecutive high cycles and saturating low cycles of the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_hi <= '0;
            run_lo <= RUN_W'(LOW_CYC);
        end else if (e_out) begin
            run_hi <= run_hi + 1'b1;
            run_lo <= '0;
        end else begin
            run_hi <= '0;
            if (run_lo < RUN_W'(LOW_CYC)) run_lo <= run_lo + 1'b1;
        end
    end

    AST_E_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(e_out) |-> run_hi == RUN_W'(HIGH_CYC)); // R3
    AST_E_LOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(e_out) |-> run_lo >= RUN_W'(LOW_CYC)); // R3

endmodule

// File: rtl/lcdbus_nibble.sv
// Data path steering. It selects the byte or the nibble to drive and merges
// read data into the assembly register. In nibble mode only the upper half
// of the bus carries data and the lower half is driven to zero.
// Assumes DATA_W is even.
module lcdbus_nibble #(
    parameter int DATA_W = 8
) (
    input  logic              four_bit,
    input  logic              nib_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] db_in,
    input  logic [DATA_W-1:0] asm_in,
    output logic [DATA_W-1:0] db_out,
    output logic [DATA_W-1:0] asm_next
);
    localparam int NIB_W = DATA_W / 2;

    logic [NIB_W-1:0] hi_w, lo_w, hi_in;

    assign hi_w  = wdata[DATA_W-1:NIB_W];
    assign lo_w  = wdata[NIB_W-1:0];
    assign hi_in = db_in[DATA_W-1:NIB_W];

    // Pick the value placed on the bus for the current strobe.
    always_comb begin
        if (!four_bit)    db_out = wdata;
        else if (!nib_sel) db_out = {hi_w, {NIB_W{1'b0}}};
        else              db_out = {lo_w, {NIB_W{1'b0}}};
    end

    // Merge sampled bus data into the byte under assembly.
    always_comb begin
        if (!four_bit)    asm_next = db_in;
        else if (!nib_sel) asm_next = {hi_in, asm_in[NIB_W-1:0]};
        else              asm_next = {asm_in[DATA_W-1:NIB_W], hi_in};
    end

endmodule

// File: rtl/lcdbus_engine.sv
// Bus cycle engine for a parallel character display controller. It takes one
// request while idle and runs one or two strobes per byte. In poll mode it
// repeats status reads until the busy bit clears or the limit is reached.
// Assumes the requester holds the request fields only for the accept cycle.
module lcdbus_engine
    import lcdbus_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_AS_NS       = 30,
    parameter int T_AH_NS       = 10,
    parameter int T_PW_NS       = 150,
    parameter int T_CYC_NS      = 400,
    parameter int T_DSW_NS      = 40,
    parameter int T_DH_NS       = 10,
    parameter int T_DDR_NS      = 100,
    parameter int DATA_W        = 8,
    parameter int POLL_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_rs,
    input  logic              req_rw,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_nibble,
    input  logic              req_poll,
    input  logic [POLL_W-1:0] poll_limit,
    output logic              busy_o,
    output logic              done,
    output logic              timeout_err,
    output logic [DATA_W-1:0] rd_data,
    output logic              lcd_rs,
    output logic              lcd_rw,
    output logic              lcd_e,
    output logic [DATA_W-1:0] lcd_db_out,
    output logic              lcd_db_oe,
    input  logic [DATA_W-1:0] lcd_db_in
);
    localparam int SETUP_CYC = imax(1, ns2cyc(T_AS_NS, CLK_PERIOD_NS));
    localparam int HIGH_CYC  = imax(ns2cyc(T_PW_NS, CLK_PERIOD_NS),
                               imax(ns2cyc(T_DSW_NS, CLK_PERIOD_NS),
                                    ns2cyc(T_DDR_NS, CLK_PERIOD_NS) + 1));
    localparam int LOW_RAW   = imax(ns2cyc(T_PW_NS, CLK_PERIOD_NS),
                               imax(ns2cyc(T_AH_NS, CLK_PERIOD_NS),
                                    ns2cyc(T_DH_NS, CLK_PERIOD_NS)));
    localparam int LOW_CYC   = imax(1, imax(LOW_RAW,
                                    ns2cyc(T_CYC_NS, CLK_PERIOD_NS) - HIGH_CYC));

    seq_t              sq;
    logic              rs_q, rw_q, m4_q, poll_q, nib_q;
    logic [DATA_W-1:0] wd_q, asm_q, rd_q;
    logic [POLL_W-1:0] lim_q, pcnt;
    logic              done_q, to_q;
    logic              stb_start, stb_e, stb_sample, stb_fin;
    logic [DATA_W-1:0] asm_next, db_mux;
    logic              more_polls;

    assign stb_start  = (sq == SQ_LAUNCH);
    assign more_polls = ({1'b0, pcnt} + 1'b1) < {1'b0, lim_q};

    lcdbus_strobe #(
        .SETUP_CYC (SETUP_CYC),
        .HIGH_CYC  (HIGH_CYC),
        .LOW_CYC   (LOW_CYC)
    ) u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (stb_start),
        .e_out  (stb_e),
        .sample (stb_sample),
        .fin    (stb_fin)
    );

    lcdbus_nibble #(
        .DATA_W (DATA_W)
    ) u_nibble (
        .four_bit (m4_q),
        .nib_sel  (nib_q),
        .wdata    (wd_q),
        .db_in    (lcd_db_in),
        .asm_in   (asm_q),
        .db_out   (db_mux),
        .asm_next (asm_next)
    );

    // Sequence strobes for one access, nibble halves and poll repeats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq     <= SQ_IDLE;
            rs_q   <= 1'b0;
            rw_q   <= 1'b0;
            m4_q   <= 1'b0;
            poll_q <= 1'b0;
            nib_q  <= 1'b0;
            wd_q   <= '0;
            asm_q  <= '0;
            rd_q   <= '0;
            lim_q  <= '0;
            pcnt   <= '0;
            done_q <= 1'b0;
            to_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            to_q   <= 1'b0;
            case (sq)
                SQ_IDLE: begin
                    if (req_valid) begin
                        rs_q   <= req_poll ? 1'b0 : req_rs;
                        rw_q   <= req_poll ? 1'b1 : req_rw;
                        wd_q   <= req_data;
                        m4_q   <= req_nibble;
                        poll_q <= req_poll;
                        lim_q  <= (poll_limit == '0) ? POLL_W'(1) : poll_limit;
                        pcnt   <= '0;
                        nib_q  <= 1'b0;
                        sq     <= SQ_LAUNCH;
                    end
                end
                SQ_LAUNCH: sq <= SQ_WAIT;
                SQ_WAIT: begin
                    if (stb_sample) asm_q <= asm_next;
                    if (stb_fin) begin
                        if (m4_q && !nib_q) begin
                            nib_q <= 1'b1;
                            sq    <= SQ_LAUNCH;
                        end else if (poll_q && asm_q[DATA_W-1] && more_polls) begin
                            pcnt  <= pcnt + 1'b1;
                            nib_q <= 1'b0;
                            sq    <= SQ_LAUNCH;
                        end else begin
                            sq     <= SQ_IDLE;
                            done_q <= 1'b1;
                            to_q   <= poll_q && asm_q[DATA_W-1];
                            if (rw_q) rd_q <= asm_q;
                        end
                    end
                end
                default: sq <= SQ_IDLE;
            endcase
        end
    end

    assign busy_o      = (sq != SQ_IDLE);
    assign done        = done_q;
    assign timeout_err = to_q;
    assign rd_data     = rd_q;
    assign lcd_rs      = rs_q;
    assign lcd_rw      = rw_q;
    assign lcd_e       = stb_e;
    assign lcd_db_out  = db_mux;
    assign lcd_db_oe   = busy_o && !rw_q;

    AST_CTRL_STEADY_E: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_e |-> $stable(lcd_rs) && $stable(lcd_rw)); // R2
    AST_DATA_HOLD_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_e) |-> $stable(lcd_db_out) && $stable(lcd_db_oe)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_E_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !lcd_e); // R7
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && req_valid) |=> $stable(lcd_rs) && $stable(lcd_rw)); // R8
    AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> done); // R10

endmodule

// File: tb/tb_lcdbus_engine.sv
module tb_lcdbus_engine;
    localparam int PER       = 20;
    localparam int EXP_SETUP = (30 + PER - 1) / PER;
    localparam int EXP_HIGH  = 8;
    localparam int EXP_LOW   = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_rs = 1'b0, req_rw = 1'b0;
    logic [7:0] req_data = '0;
    logic       req_nibble = 1'b0, req_poll = 1'b0;
    logic [7:0] poll_limit = '0;
    logic       busy_o, done, timeout_err;
    logic [7:0] rd_data;
    logic       lcd_rs, lcd_rw, lcd_e, lcd_db_oe;
    logic [7:0] lcd_db_out;
    logic [7:0] lcd_db_in;

    always #(PER/2) clk = ~clk;

    lcdbus_engine dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rs(req_rs),
        .req_rw(req_rw), .req_data(req_data), .req_nibble(req_nibble),
        .req_poll(req_poll), .poll_limit(poll_limit), .busy_o(busy_o),
        .done(done), .timeout_err(timeout_err), .rd_data(rd_data),
        .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e),
        .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe), .lcd_db_in(lcd_db_in)
    );

    int total = 0, fails = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // Display model: busy for the first dev_busy bytes, then returns dev_ac.
    logic       dev_m4 = 1'b0;
    int         dev_busy = 0;
    logic [7:0] dev_ac = '0;
    int         n_e = 0;

    always_comb begin
        int bidx;
        logic [7:0] cur;
        bidx = dev_m4 ? ((n_e - 1) >>> 1) : (n_e - 1);
        cur  = (bidx < dev_busy) ? (8'h80 | dev_ac) : dev_ac;
        if (!dev_m4)            lcd_db_in = cur;
        else if (((n_e - 1) & 1) == 0) lcd_db_in = {cur[7:4], 4'hA};
        else                    lcd_db_in = {cur[3:0], 4'h5};
    end

    // Bus monitor sampled on the falling clock edge.
    int   hi_cnt = 0, lo_cnt = 1000, ctrl_age = 1000;
    int   setup_bad = 0, ctrl_bad = 0, hi_bad = 0, lo_bad = 0, oe_bad = 0, done_bad = 0;
    logic prev_e = 0, prev_rs = 0, prev_rw = 0, prev_done = 0;
    logic [7:0] last_db = '0;
    logic last_oe = 0, obs_rs = 0, obs_rw = 0;
    logic [7:0] wr_seen [2];
    logic       oe_seen [2];

    always @(negedge clk) begin
        if (rst_n) begin
            if (lcd_rs !== prev_rs || lcd_rw !== prev_rw) begin
                if (lcd_e && prev_e) ctrl_bad++;
                ctrl_age = 0;
            end else ctrl_age++;
            if (lcd_e && !prev_e) begin
                n_e++;
                if (ctrl_age < EXP_SETUP) setup_bad++;
                if (lo_cnt < EXP_LOW) lo_bad++;
                hi_cnt = 0;
                obs_rs = lcd_rs;
                obs_rw = lcd_rw;
            end
            if (lcd_e) begin
                hi_cnt++;
                last_db = lcd_db_out;
                last_oe = lcd_db_oe;
            end
            if (!lcd_e && prev_e) begin
                if (hi_cnt != EXP_HIGH) hi_bad++;
                if (n_e >= 1 && n_e <= 2) begin
                    wr_seen[n_e-1] = last_db;
                    oe_seen[n_e-1] = last_oe;
                end
                lo_cnt = 0;
            end
            if (!lcd_e) lo_cnt++;
            if (lcd_rw && lcd_db_oe) oe_bad++;
            if (done && prev_done) done_bad++;
            prev_e = lcd_e; prev_rs = lcd_rs; prev_rw = lcd_rw; prev_done = done;
        end
    end

    logic obs_to = 0;

    task automatic issue(input logic rs, input logic rw, input logic m4, input logic poll,
                         input logic [7:0] data, input logic [7:0] lim,
                         input int bsy, input logic [7:0] ac);
        @(negedge clk); #1;
        n_e = 0; dev_m4 = m4; dev_busy = bsy; dev_ac = ac;
        wr_seen[0] = 'x; wr_seen[1] = 'x;
        req_valid = 1; req_rs = rs; req_rw = rw; req_nibble = m4;
        req_poll = poll; req_data = data; poll_limit = lim;
        @(negedge clk); #1;
        req_valid = 0;
    endtask

    task automatic wait_done();
        bit seen = 0;
        obs_to = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (done) begin seen = 1; obs_to = timeout_err; break; end
        end
        chk(seen, "R7 done within limit", int'(seen), 1);
    endtask

    task automatic flags_ok(input string tag);
        chk(setup_bad == 0, {"R2 setup ", tag}, setup_bad, 0);
        chk(ctrl_bad == 0, {"R2 stable ", tag}, ctrl_bad, 0);
        chk(hi_bad == 0 && lo_bad == 0, {"R3 widths ", tag}, hi_bad + lo_bad, 0);
        chk(oe_bad == 0, {"R5 no drive on read ", tag}, oe_bad, 0);
        chk(done_bad == 0, {"R7 pulse ", tag}, done_bad, 0);
    endtask

    // Vectors: {rs, rw, nibble, data[7:0], resp[7:0]}
    localparam logic [18:0] VEC [6] = '{
        {1'b1, 1'b0, 1'b0, 8'hA5, 8'h00},
        {1'b0, 1'b0, 1'b0, 8'h38, 8'h00},
        {1'b1, 1'b0, 1'b1, 8'hC3, 8'h00},
        {1'b1, 1'b1, 1'b0, 8'h00, 8'h5A},
        {1'b1, 1'b1, 1'b1, 8'h00, 8'hE7},
        {1'b0, 1'b1, 1'b1, 8'h00, 8'h26}
    };

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        logic [7:0] exp_rd;
        repeat (3) @(negedge clk);
        // R1 reset state while held and after release
        chk(lcd_e == 0 && lcd_db_oe == 0, "R1 bus idle in reset", {lcd_e, lcd_db_oe}, 0);
        chk(done == 0 && busy_o == 0 && timeout_err == 0, "R1 status in reset",
            {done, busy_o, timeout_err}, 0);
        #1 rst_n = 1;
        repeat (2) @(negedge clk);
        chk(lcd_e == 0 && lcd_db_oe == 0 && busy_o == 0, "R1 after reset",
            {lcd_e, lcd_db_oe, busy_o}, 0);

        exp_rd = 8'h00;
        for (int v = 0; v < 6; v++) begin
            logic rs, rw, m4;
            logic [7:0] d, r;
            {rs, rw, m4, d, r} = VEC[v];
            issue(rs, rw, m4, 1'b0, d, 8'd1, 0, r);
            wait_done();
            chk(n_e == (m4 ? 2 : 1), "R7 strobe count", n_e, m4 ? 2 : 1);
            chk(obs_rs == rs && obs_rw == rw, "R2 control values", {obs_rs, obs_rw}, {rs, rw});
            if (!rw) begin
                if (!m4) begin
                    chk(wr_seen[0] == d && oe_seen[0], "R4 byte write", wr_seen[0], d);
                end else begin
                    chk(wr_seen[0] == {d[7:4], 4'h0} && oe_seen[0], "R6 high nibble first",
                        wr_seen[0], {d[7:4], 4'h0});
                    chk(wr_seen[1] == {d[3:0], 4'h0} && oe_seen[1], "R6 low nibble second",
                        wr_seen[1], {d[3:0], 4'h0});
                end
                chk(rd_data == exp_rd, "R11 write keeps rd_data", rd_data, exp_rd);
            end else begin
                exp_rd = r;
                chk(rd_data == r, m4 ? "R6 nibble read assembly" : "R5 byte read",
                    rd_data, r);
            end
            chk(obs_to == 0, "R10 no timeout outside poll", obs_to, 0);
            flags_ok("vector");
        end

        // R8: request during an access is ignored
        issue(1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 8'd1, 0, 8'h00);
        repeat (4) @(negedge clk);
        #1 req_valid = 1; req_rs = 0; req_rw = 1; req_data = 8'hFF; req_nibble = 1;
        @(negedge clk); #1 req_valid = 0;
        wait_done();
        repeat (40) @(negedge clk);
        chk(n_e == 1, "R8 no extra strobe", n_e, 1);
        chk(wr_seen[0] == 8'h3C, "R8 access unchanged", wr_seen[0], 8'h3C);
        chk(busy_o == 0, "R8 idle afterwards", busy_o, 0);

        // R9: byte poll, request fields overridden, clears after 3 busy reads
        issue(1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'd8, 3, 8'h15);
        wait_done();
        chk(n_e == 4, "R9 byte poll reads", n_e, 4);
        chk(rd_data == 8'h15 && obs_to == 0, "R9 byte poll result", rd_data, 8'h15);
        chk(obs_rs == 0 && obs_rw == 1, "R9 status access forced", {obs_rs, obs_rw}, 1);

        // R9: nibble poll, busy for 2 bytes
        issue(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'd8, 2, 8'h4B);
        wait_done();
        chk(n_e == 6, "R9 nibble poll strobes", n_e, 6);
        chk(rd_data == 8'h4B && obs_to == 0, "R9 nibble poll result", rd_data, 8'h4B);

        // R10: timeout after limit reads
        issue(1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'd4, 100, 8'h22);
        wait_done();
        chk(n_e == 4, "R10 read count at limit", n_e, 4);
        chk(obs_to == 1, "R10 timeout flag", obs_to, 1);
        chk(rd_data == 8'hA2, "R10 last status kept", rd_data, 8'hA2);

        // R10: limit zero acts as one
        issue(1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'd0, 100, 8'h07);
        wait_done();
        chk(n_e == 1 && obs_to == 1, "R10 zero limit", n_e, 1);
        flags_ok("poll");

        summary();
        $finish;
    end
endmodule